// File: doc/BRIEF.md
# Selective Huffman Serial Test Decompressor

This block sits between a single serial tester channel and a scan chain. It rebuilds fixed-size scan blocks from a compressed bit stream. The tester delivers one bit per strobe. Each word in the stream opens with one flag bit. A flag of 1 introduces a variable-length prefix-free codeword, which is looked up in a loadable table to give one of the frequently used block values. A flag of 0 introduces an uncoded block whose `BLOCK_W` bits follow in scan order.

A serializer shifts each finished block out on the fast clock, one scan bit per cycle, while the decoder already takes in the bits of the next word. The tester strobes arrive at most once every `STROBE_GAP` fast clocks. A one-block holding stage absorbs a block that completes while the previous one is still shifting. While that stage is occupied, a stall output tells the tester to hold off. A lane parameter lets two copies share one tester channel, one taking the even-numbered strobes and the other the odd-numbered ones.

Top module: `shd_decomp`

## Requirements
- R1: After reset, scanValid, stall and errSticky are low and every table entry has length 0, so a Huffman word then raises errSticky on its first code bit and yields no block.
- R2: A word whose flag bit is 0 is followed by exactly BLOCK_W data bits. The first data bit received is the block's most significant bit, and the block is shifted out on scanOut most significant bit first.
- R3: A word whose flag bit is 1 yields the block value of the table entry whose length equals the number of code bits received so far and whose codeword matches them. The codeword is right-aligned, and the first code bit received is its most significant bit. An entry of length 0 never matches. A correctly loaded table is prefix-free, so at most one entry matches.
- R4: Each accepted strobe consumes exactly one bit. Strobes are at least STROBE_GAP fast clocks apart. The flag of the next word may arrive on the strobe right after the last bit of the previous word, and any mix of coded and uncoded words decodes in order.
- R5: With the serializer idle, scanValid is high and scanOut carries the block's first bit in the clock cycle after the strobe that completes a word. scanValid then stays high for exactly BLOCK_W cycles.
- R6: A block completed while the serializer is busy is held, and stall is high while it is held. It starts shifting on the cycle after the current block's last bit, so the two blocks form one unbroken run of scanValid.
- R7: A bit offered while stall is high is discarded, leaving the decoder state unchanged, and it sets errSticky.
- R8: When the number of Huffman code bits received exceeds the longest loaded entry length, errSticky is set, no block is produced, and the next bit is taken as a flag.
- R9: errSticky stays high until reset.
- R10: With LANE_SEL 0 every strobe is taken. With 1 only even-numbered strobes are taken, and with 2 only odd-numbered ones, where the first strobe after reset is number 0.
- R11: A configuration write stores a length, a codeword and a block value at cfgAddr. Rewriting an entry changes the block its codeword decodes to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast scan clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitValid | input | 1 | Tester strobe, one cycle per delivered bit |
| bitIn | input | 1 | Tester data bit |
| cfgWe | input | 1 | Table entry write enable |
| cfgAddr | input | $clog2(TABLE_N) | Table entry index |
| cfgLen | input | $clog2(CODE_MAX+1) | Codeword length, 0 marks the entry empty |
| cfgCode | input | CODE_MAX | Right-aligned codeword bits |
| cfgBlock | input | BLOCK_W | Block value the codeword stands for |
| scanOut | output | 1 | Serial scan data, most significant bit first |
| scanValid | output | 1 | scanOut carries a block bit this cycle |
| stall | output | 1 | A finished block is waiting, tester must pause |
| errSticky | output | 1 | Overlength codeword or bit sent during stall |

## Verification
The decoder is driven with every loaded codeword length from one to six bits, with uncoded blocks, and with a seeded random mix of both sent back to back, which separates table lookup from pass-through and exposes any bit-order or word-boundary slip. Pairs of shortest codewords force the holding stage and stall, and an extra bit forced in during stall shows whether it is dropped rather than consumed. An unmatched all-ones code run longer than any entry, an empty table after reset and a rewritten entry test the error and configuration paths. A shared channel feeding an even-lane and an odd-lane copy with different data checks that each copy takes only its own strobes.

// File: rtl/shd_pkg.sv
package shd_pkg;

  typedef enum logic [1:0] {
    ST_FLAG = 2'd0,
    ST_HUFF = 2'd1,
    ST_RAW  = 2'd2
  } decState_t;

  // strobes from the control FSM into the accumulator datapath
  typedef struct packed {
    logic clear;
    logic shift;
  } dpStrobe_t;

endpackage

// File: rtl/shd_data.sv
module shd_data #(
  parameter int BLOCK_W  = 8,
  parameter int CODE_MAX = 12,
  parameter int TABLE_N  = 32,
  localparam int ADDR_W  = $clog2(TABLE_N),
  localparam int LEN_W   = $clog2(CODE_MAX + 1),
  localparam int CNT_MAX = (BLOCK_W > CODE_MAX + 1) ? BLOCK_W : CODE_MAX + 1,
  localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgWe,
  input  logic [ADDR_W-1:0]       cfgAddr,
  input  logic [LEN_W-1:0]        cfgLen,
  input  logic [CODE_MAX-1:0]     cfgCode,
  input  logic [BLOCK_W-1:0]      cfgBlock,
  input  shd_pkg::dpStrobe_t      strobe,
  input  logic                    bitIn,
  output logic                    hit,
  output logic [BLOCK_W-1:0]      hitBlock,
  output logic [BLOCK_W-1:0]      rawBlock,
  output logic [CNT_W-1:0]        countNext,
  output logic [LEN_W-1:0]        maxLen
);

  localparam int ACC_W = (BLOCK_W > CODE_MAX) ? BLOCK_W : CODE_MAX;

  logic [LEN_W-1:0]    lenTab  [TABLE_N];
  logic [CODE_MAX-1:0] codeTab [TABLE_N];
  logic [BLOCK_W-1:0]  blkTab  [TABLE_N];

  logic [ACC_W-2:0]    acc;
  logic [ACC_W-1:0]    accNext;
  logic [CNT_W-1:0]    cnt;
  logic [TABLE_N-1:0]  hitVec;

  function automatic logic [CODE_MAX-1:0] lenMask(input logic [LEN_W-1:0] n);
    logic [CODE_MAX-1:0] m;
    for (int i = 0; i < CODE_MAX; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  // table storage, codeword bits above the length are forced to zero
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < TABLE_N; i++) begin
        lenTab[i]  <= '0;
        codeTab[i] <= '0;
        blkTab[i]  <= '0;
      end
    end else if (cfgWe) begin
      lenTab[cfgAddr]  <= cfgLen;
      codeTab[cfgAddr] <= cfgCode & lenMask(cfgLen);
      blkTab[cfgAddr]  <= cfgBlock;
    end
  end

  assign accNext   = {acc, bitIn};
  assign countNext = cnt + 1'b1;
  assign rawBlock  = accNext[BLOCK_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
      cnt <= '0;
    end else if (strobe.clear) begin
      acc <= '0;
      cnt <= '0;
    end else if (strobe.shift) begin
      acc <= accNext[ACC_W-2:0];
      cnt <= countNext;
    end
  end

  // parallel match of the next accumulator value against every entry
  for (genvar g = 0; g < TABLE_N; g++) begin : gMatch
    assign hitVec[g] = (lenTab[g] != '0) &&
                       (CNT_W'(lenTab[g]) == countNext) &&
                       (codeTab[g] == accNext[CODE_MAX-1:0]);
  end

  assign hit = |hitVec;

  always_comb begin
    hitBlock = '0;
    for (int i = 0; i < TABLE_N; i++)
      if (hitVec[i]) hitBlock = hitBlock | blkTab[i];
  end

  always_comb begin
    maxLen = '0;
    for (int i = 0; i < TABLE_N; i++)
      if (lenTab[i] > maxLen) maxLen = lenTab[i];
  end

  // R3
  single_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |-> $onehot0(hitVec));

endmodule

// File: rtl/shd_ctrl.sv
module shd_ctrl #(
  parameter int BLOCK_W    = 8,
  parameter int CODE_MAX   = 12,
  parameter int STROBE_GAP = 2,
  parameter int LANE_SEL   = 0,
  localparam int LEN_W     = $clog2(CODE_MAX + 1),
  localparam int CNT_MAX   = (BLOCK_W > CODE_MAX + 1) ? BLOCK_W : CODE_MAX + 1,
  localparam int CNT_W     = $clog2(CNT_MAX + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitValid,
  input  logic               bitIn,
  input  logic               stall,
  input  logic               hit,
  input  logic [CNT_W-1:0]   countNext,
  input  logic [LEN_W-1:0]   maxLen,
  output shd_pkg::dpStrobe_t strobe,
  output logic               emitHuff,
  output logic               emitRaw,
  output logic               errSticky
);
  import shd_pkg::*;

  localparam int GAP_W = $clog2(STROBE_GAP + 1);

  decState_t         state, stateNext;
  logic              parity;
  logic              laneMine;
  logic              take;
  logic              dropBit;
  logic              ovlErr;
  logic [GAP_W-1:0]  gapCnt;

  // strobe numbering for channel sharing
  always_ff @(posedge clk) begin
    if (!rstN)         parity <= 1'b0;
    else if (bitValid) parity <= ~parity;
  end

  always_comb begin
    case (LANE_SEL)
      1:       laneMine = ~parity;
      2:       laneMine = parity;
      default: laneMine = 1'b1;
    endcase
  end

  assign take    = bitValid && laneMine && !stall;
  assign dropBit = bitValid && laneMine && stall;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    emitHuff  = 1'b0;
    emitRaw   = 1'b0;
    ovlErr    = 1'b0;
    if (take) begin
      case (state)
        ST_FLAG: begin
          strobe.clear = 1'b1;
          stateNext    = bitIn ? ST_HUFF : ST_RAW;
        end
        ST_HUFF: begin
          strobe.shift = 1'b1;
          if (hit) begin
            emitHuff  = 1'b1;
            stateNext = ST_FLAG;
          end else if (countNext > CNT_W'(maxLen)) begin
            ovlErr    = 1'b1;
            stateNext = ST_FLAG;
          end
        end
        ST_RAW: begin
          strobe.shift = 1'b1;
          if (countNext == CNT_W'(BLOCK_W)) begin
            emitRaw   = 1'b1;
            stateNext = ST_FLAG;
          end
        end
        default: stateNext = ST_FLAG;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_FLAG;
      errSticky <= 1'b0;
    end else begin
      state     <= stateNext;
      errSticky <= errSticky | ovlErr | dropBit;
    end
  end

  // cycles since the last strobe, saturating
  always_ff @(posedge clk) begin
    if (!rstN)                              gapCnt <= GAP_W'(STROBE_GAP);
    else if (bitValid)                      gapCnt <= '0;
    else if (gapCnt != GAP_W'(STROBE_GAP))  gapCnt <= gapCnt + 1'b1;
  end

  // R4
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> (gapCnt >= GAP_W'(STROBE_GAP - 1)));

  // R8
  ovl_recover_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovlErr |=> (state == ST_FLAG));

endmodule

// File: rtl/shd_serial.sv
module shd_serial #(
  parameter int BLOCK_W = 8,
  localparam int LEFT_W = $clog2(BLOCK_W + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               emit,
  input  logic [BLOCK_W-1:0] emitBlock,
  output logic               scanOut,
  output logic               scanValid,
  output logic               stall
);

  logic [BLOCK_W-1:0] shReg;
  logic [BLOCK_W-1:0] pendReg;
  logic               pendValid;
  logic [LEFT_W-1:0]  shLeft;
  logic               free;

  assign free = (shLeft <= LEFT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg     <= '0;
      pendReg   <= '0;
      pendValid <= 1'b0;
      shLeft    <= '0;
    end else if (free) begin
      if (pendValid) begin
        shReg     <= pendReg;
        shLeft    <= LEFT_W'(BLOCK_W);
        pendValid <= 1'b0;
      end else if (emit) begin
        shReg  <= emitBlock;
        shLeft <= LEFT_W'(BLOCK_W);
      end else begin
        shReg  <= shReg << 1;
        shLeft <= '0;
      end
    end else begin
      shReg  <= shReg << 1;
      shLeft <= shLeft - 1'b1;
      if (emit) begin
        pendReg   <= emitBlock;
        pendValid <= 1'b1;
      end
    end
  end

  assign scanOut   = shReg[BLOCK_W-1];
  assign scanValid = (shLeft != '0);
  assign stall     = pendValid;

  // R6
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    emit |-> !pendValid);

  // R6
  held_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendValid |-> scanValid);

endmodule

// File: rtl/shd_decomp.sv
module shd_decomp #(
  parameter int BLOCK_W    = 8,
  parameter int CODE_MAX   = 12,
  parameter int TABLE_N    = 32,
  parameter int STROBE_GAP = 2,
  parameter int LANE_SEL   = 0,
  localparam int ADDR_W    = $clog2(TABLE_N),
  localparam int LEN_W     = $clog2(CODE_MAX + 1),
  localparam int CNT_MAX   = (BLOCK_W > CODE_MAX + 1) ? BLOCK_W : CODE_MAX + 1,
  localparam int CNT_W     = $clog2(CNT_MAX + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitValid,
  input  logic                bitIn,
  input  logic                cfgWe,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [LEN_W-1:0]    cfgLen,
  input  logic [CODE_MAX-1:0] cfgCode,
  input  logic [BLOCK_W-1:0]  cfgBlock,
  output logic                scanOut,
  output logic                scanValid,
  output logic                stall,
  output logic                errSticky
);

  shd_pkg::dpStrobe_t  strobe;
  logic                hit;
  logic [BLOCK_W-1:0]  hitBlock;
  logic [BLOCK_W-1:0]  rawBlock;
  logic [CNT_W-1:0]    countNext;
  logic [LEN_W-1:0]    maxLen;
  logic                emitHuff;
  logic                emitRaw;
  logic                emit;
  logic [BLOCK_W-1:0]  emitBlock;

  shd_ctrl #(
    .BLOCK_W(BLOCK_W), .CODE_MAX(CODE_MAX),
    .STROBE_GAP(STROBE_GAP), .LANE_SEL(LANE_SEL)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn),
    .stall(stall), .hit(hit), .countNext(countNext), .maxLen(maxLen),
    .strobe(strobe), .emitHuff(emitHuff), .emitRaw(emitRaw),
    .errSticky(errSticky)
  );

  shd_data #(
    .BLOCK_W(BLOCK_W), .CODE_MAX(CODE_MAX), .TABLE_N(TABLE_N)
  ) uData (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgLen(cfgLen), .cfgCode(cfgCode), .cfgBlock(cfgBlock),
    .strobe(strobe), .bitIn(bitIn), .hit(hit), .hitBlock(hitBlock),
    .rawBlock(rawBlock), .countNext(countNext), .maxLen(maxLen)
  );

  assign emit      = emitHuff | emitRaw;
  assign emitBlock = emitHuff ? hitBlock : rawBlock;

  shd_serial #(.BLOCK_W(BLOCK_W)) uSerial (
    .clk(clk), .rstN(rstN), .emit(emit), .emitBlock(emitBlock),
    .scanOut(scanOut), .scanValid(scanValid), .stall(stall)
  );

endmodule

// File: tb/shd_decomp_test.sv
module shd_decomp_test;

  localparam int W   = 8;
  localparam int CM  = 12;
  localparam int TN  = 32;
  localparam int GAP = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitValid = 1'b0, bitIn = 1'b0;
  logic laneValid = 1'b0, laneBit = 1'b0;
  logic cfgWe = 1'b0;
  logic [4:0] cfgAddr = '0;
  logic [3:0] cfgLen = '0;
  logic [CM-1:0] cfgCode = '0;
  logic [W-1:0] cfgBlock = '0;
  logic scanOut, scanValid, stall, errSticky;
  logic outE, validE, stallE, errE;
  logic outO, validO, stallO, errO;

  int nChecks = 0, nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  shd_decomp #(.BLOCK_W(W), .CODE_MAX(CM), .TABLE_N(TN), .STROBE_GAP(GAP), .LANE_SEL(0)) uut (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn), .cfgWe(cfgWe),
    .cfgAddr(cfgAddr), .cfgLen(cfgLen), .cfgCode(cfgCode), .cfgBlock(cfgBlock),
    .scanOut(scanOut), .scanValid(scanValid), .stall(stall), .errSticky(errSticky));

  shd_decomp #(.BLOCK_W(W), .CODE_MAX(CM), .TABLE_N(TN), .STROBE_GAP(1), .LANE_SEL(1)) uutEven (
    .clk(clk), .rstN(rstN), .bitValid(laneValid), .bitIn(laneBit), .cfgWe(cfgWe),
    .cfgAddr(cfgAddr), .cfgLen(cfgLen), .cfgCode(cfgCode), .cfgBlock(cfgBlock),
    .scanOut(outE), .scanValid(validE), .stall(stallE), .errSticky(errE));

  shd_decomp #(.BLOCK_W(W), .CODE_MAX(CM), .TABLE_N(TN), .STROBE_GAP(1), .LANE_SEL(2)) uutOdd (
    .clk(clk), .rstN(rstN), .bitValid(laneValid), .bitIn(laneBit), .cfgWe(cfgWe),
    .cfgAddr(cfgAddr), .cfgLen(cfgLen), .cfgCode(cfgCode), .cfgBlock(cfgBlock),
    .scanOut(outO), .scanValid(validO), .stall(stallO), .errSticky(errO));

  // bench copy of the prefix-free code table
  int          benchAddr [6] = '{0, 1, 2, 3, 4, 31};
  int          benchLen  [6] = '{1, 2, 3, 4, 5, 6};
  int          benchCode [6] = '{0, 2, 6, 14, 30, 62};
  logic [W-1:0] benchBlk [6] = '{8'h00, 8'hFF, 8'h0F, 8'hF0, 8'h3C, 8'hA5};

  logic [W-1:0] gotM[$], expM[$], gotE[$], expE[$], gotO[$], expO[$];
  logic [W-1:0] asmM, asmE, asmO;
  int cntM, cntE, cntO, runM, maxRunM;

  // collectors sample away from the active edge
  always @(negedge clk) begin
    if (!rstN) begin
      cntM = 0; cntE = 0; cntO = 0; runM = 0;
    end else begin
      if (scanValid) begin
        asmM = {asmM[W-2:0], scanOut}; cntM++; runM++;
        if (runM > maxRunM) maxRunM = runM;
        if (cntM == W) begin gotM.push_back(asmM); cntM = 0; end
      end else runM = 0;
      if (validE) begin
        asmE = {asmE[W-2:0], outE}; cntE++;
        if (cntE == W) begin gotE.push_back(asmE); cntE = 0; end
      end
      if (validO) begin
        asmO = {asmO[W-2:0], outO}; cntO++;
        if (cntO == W) begin gotO.push_back(asmO); cntO = 0; end
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    gotM.delete(); expM.delete(); gotE.delete(); expE.delete();
    gotO.delete(); expO.delete();
  endtask

  task automatic cfgWrite(input int addr, input int len, input int code, input logic [W-1:0] blk);
    cfgWe = 1'b1; cfgAddr = addr[4:0]; cfgLen = len[3:0]; cfgCode = code[CM-1:0]; cfgBlock = blk;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic loadTable();
    for (int i = 0; i < 6; i++) cfgWrite(benchAddr[i], benchLen[i], benchCode[i], benchBlk[i]);
  endtask

  task automatic sendBit(input logic b);
    while (stall) @(negedge clk);
    bitValid = 1'b1; bitIn = b;
    @(negedge clk);
    bitValid = 1'b0;
    repeat (GAP - 1) @(negedge clk);
  endtask

  task automatic sendBlock(input logic [W-1:0] b);
    int idx;
    idx = -1;
    for (int i = 0; i < 6; i++) if (idx < 0 && benchBlk[i] == b) idx = i;
    if (idx >= 0) begin
      sendBit(1'b1);
      for (int k = benchLen[idx] - 1; k >= 0; k--) sendBit(benchCode[idx][k]);
    end else begin
      sendBit(1'b0);
      for (int k = W - 1; k >= 0; k--) sendBit(b[k]);
    end
    expM.push_back(b);
  endtask

  task automatic drain();
    repeat (4 * W + 8) @(negedge clk);
  endtask

  task automatic compareQ(input logic [W-1:0] got[$], input logic [W-1:0] exp[$], input string req);
    check(got.size() == exp.size(), {req, " block count"}, got.size(), exp.size());
    for (int i = 0; i < exp.size() && i < got.size(); i++)
      check(got[i] == exp[i], req, got[i], exp[i]);
  endtask

  function automatic logic rawBitOf(input logic [W-1:0] w, input int pos);
    return (pos == 0) ? 1'b0 : w[W - pos];
  endfunction

  task automatic laneSend(input logic b);
    while (stallE || stallO) @(negedge clk);
    laneValid = 1'b1; laneBit = b;
    @(negedge clk);
    laneValid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] wordA [3];
    logic [W-1:0] wordB [3];
    logic [W-1:0] rb;
    int run;
    void'($urandom(32'd24681));

    // R1: reset state
    repeat (2) @(negedge clk);
    check(scanValid == 1'b0, "R1 scanValid in reset", scanValid, 0);
    doReset();
    check(scanValid == 1'b0, "R1 scanValid after reset", scanValid, 0);
    check(stall == 1'b0, "R1 stall after reset", stall, 0);
    check(errSticky == 1'b0, "R1 errSticky after reset", errSticky, 0);

    // R1: empty table makes any Huffman word overlong at once
    sendBit(1'b1); sendBit(1'b0);
    check(errSticky == 1'b1, "R1 empty table error", errSticky, 1);
    drain();
    check(gotM.size() == 0, "R1 empty table no block", gotM.size(), 0);

    // R2 R3: each codeword length and an uncoded block
    doReset();
    loadTable();
    for (int i = 0; i < 6; i++) sendBlock(benchBlk[i]);
    sendBlock(8'h96);
    sendBlock(8'h01);
    drain();
    compareQ(gotM, expM, "R3 R2 directed decode");
    gotM.delete(); expM.delete();

    // R5: latency and run length from an idle serializer
    rb = 8'hB4;
    sendBit(1'b0);
    for (int k = W - 1; k >= 1; k--) sendBit(rb[k]);
    bitValid = 1'b1; bitIn = rb[0];
    @(negedge clk);
    bitValid = 1'b0;
    check(scanValid == 1'b1, "R5 scanValid next cycle", scanValid, 1);
    check(scanOut == rb[W-1], "R5 first bit is MSB", scanOut, rb[W-1]);
    run = 0;
    while (scanValid && run < 4 * W) begin run++; @(negedge clk); end
    check(run == W, "R5 scanValid run length", run, W);
    expM.push_back(rb);
    drain();
    compareQ(gotM, expM, "R5 R2 block value");
    gotM.delete(); expM.delete();

    // R4: seeded random mix, back to back
    for (int n = 0; n < 60; n++) begin
      if ($urandom_range(1, 0) == 1) sendBlock(benchBlk[$urandom_range(5, 0)]);
      else sendBlock(W'($urandom()));
    end
    drain();
    compareQ(gotM, expM, "R4 random stream");
    check(errSticky == 1'b0, "R4 no false error", errSticky, 0);
    gotM.delete(); expM.delete();

    // R11: rewrite entry 1 to a new block
    cfgWrite(1, 2, 2, 8'h5A);
    benchBlk[1] = 8'h5A;
    sendBlock(8'h5A);
    drain();
    compareQ(gotM, expM, "R11 rewritten entry");
    gotM.delete(); expM.delete();

    // R6 R7: hold stage, stall, and a bit forced during stall
    maxRunM = 0;
    sendBlock(8'h00);
    sendBlock(8'h00);
    check(stall == 1'b1, "R6 stall while block held", stall, 1);
    bitValid = 1'b1; bitIn = 1'b1;
    @(negedge clk);
    bitValid = 1'b0;
    check(errSticky == 1'b1, "R7 bit during stall flagged", errSticky, 1);
    sendBlock(8'hC3);
    drain();
    check(maxRunM == 2 * W, "R6 unbroken two-block run", maxRunM, 2 * W);
    compareQ(gotM, expM, "R7 dropped bit leaves stream intact");
    gotM.delete(); expM.delete();

    // R8 R9: overlength Huffman word then recovery
    doReset();
    benchBlk[1] = 8'hFF;
    loadTable();
    for (int k = 0; k < 7; k++) sendBit(1'b1);
    check(errSticky == 1'b0, "R8 no error at longest length", errSticky, 0);
    sendBit(1'b1);
    check(errSticky == 1'b1, "R8 overlength error", errSticky, 1);
    sendBlock(8'h81);
    sendBlock(8'h0F);
    drain();
    compareQ(gotM, expM, "R8 recovery without extra block");
    repeat (50) @(negedge clk);
    check(errSticky == 1'b1, "R9 error stays set", errSticky, 1);

    // R10: shared channel, even and odd lanes
    doReset();
    loadTable();
    for (int i = 0; i < 3; i++) begin
      wordA[i] = 8'h10 + W'(i * 17);
      wordB[i] = 8'hE1 - W'(i * 9);
      expE.push_back(wordA[i]);
      expO.push_back(wordB[i]);
    end
    for (int k = 0; k < 3 * (W + 1); k++) begin
      laneSend(rawBitOf(wordA[k / (W + 1)], k % (W + 1)));
      laneSend(rawBitOf(wordB[k / (W + 1)], k % (W + 1)));
    end
    drain();
    compareQ(gotE, expE, "R10 even lane");
    compareQ(gotO, expO, "R10 odd lane");
    check((errE | errO) == 1'b0, "R10 lanes without error", errE | errO, 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

endmodule